// File: doc/BRIEF.md
# Chip-Row Select Decoder

This block sits between a byte-addressed request and a memory built from several identical, smaller memory devices. The memory holds `MEM_WORDS` words of `MEM_BITS` bits. Each device holds `DEV_WORDS` words of `DEV_BITS` bits, so the devices form a grid. There are `MEM_WORDS/DEV_WORDS` rows and `MEM_BITS/DEV_BITS` devices in each row. All devices in a row are enabled together, so that side by side they supply one full-width word.

The decoder splits the incoming byte address into four fields. The bottom field picks a byte inside a word and drives no device. The next field is the word address inside a device, and it fans out to every device. Above that, a field picks one row. The top "tag" field decides whether the access falls inside this memory's window at all. The tag is compared with `cfg_base`. In exact mode every tag bit must match. In relaxed mode the bits set in `cfg_ignore` are don't-care, so the memory appears at several aliased windows. The decoder is purely combinational: the selects follow the address and the access strobe within the same cycle.

Top module: `chip_row_decoder`

## Requirements
- R1: `dev_addr` always equals address bits [3:2] (the word index inside a device), whatever the strobe and the mode are.
- R2: On a hit, exactly one bit of `row_sel` is 1, at the index given by address bits [5:4].
- R3: With `cfg_relaxed`=0, `hit` is 1 exactly when `strobe` is 1 and address bits [7:6] equal `cfg_base`.
- R4: With `cfg_relaxed`=1, `hit` is 1 exactly when `strobe` is 1 and every tag bit whose `cfg_ignore` bit is 0 equals the matching `cfg_base` bit. The windows that differ only in ignored bits alias to the same devices.
- R5: With `cfg_relaxed`=0, `cfg_ignore` has no effect on any output.
- R6: With `strobe`=0, `hit`, `row_sel` and `dev_sel` are all 0.
- R7: When the tag does not match, `row_sel` and `dev_sel` are all 0, and `hit` is 1 exactly when some row select is asserted.
- R8: `dev_sel[r*COLS+c]` equals `row_sel[r]` for every column c, where COLS = `MEM_BITS/DEV_BITS`.
- R9: The byte offset bits [1:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | ADDR_W (8) | Byte address of the access |
| strobe | input | 1 | Access valid |
| cfg_relaxed | input | 1 | 0: exact tag compare, 1: masked compare |
| cfg_base | input | TAG_W (2) | Window base, compared with the tag field |
| cfg_ignore | input | TAG_W (2) | Tag bits treated as don't-care in relaxed mode |
| dev_addr | output | DEV_AW (2) | Word address shared by all devices |
| row_sel | output | ROWS (4) | One select per device row |
| dev_sel | output | ROWS*COLS (8) | Select per device, row-major |
| hit | output | 1 | Access falls inside the decoded window |

## Verification
The hardest case is aliasing. It only appears when relaxed mode is combined with a nonzero ignore mask and with addresses whose tags differ from the base in exactly the ignored bits. The same ignore pattern must also be shown to do nothing in exact mode. The bench therefore sweeps every combination of mode, base, ignore mask and strobe against all 256 addresses. Each output is compared with values derived from the address arithmetic. Outputs seen at byte offset 0 are kept and compared with the outputs at the other three offsets of the same word.

// File: rtl/chip_row_pkg.sv
package chip_row_pkg;

  // bits needed to select a byte inside a word of word_bits bits
  function automatic int unsigned byte_sel_bits(input int unsigned word_bits);
    return $clog2(word_bits / 8);
  endfunction

  // bits that address a word inside one device
  function automatic int unsigned dev_addr_bits(input int unsigned dev_words);
    return $clog2(dev_words);
  endfunction

  // number of device rows and its index width
  function automatic int unsigned row_count(input int unsigned mem_words,
                                            input int unsigned dev_words);
    return mem_words / dev_words;
  endfunction

  function automatic int unsigned col_count(input int unsigned mem_bits,
                                            input int unsigned dev_bits);
    return mem_bits / dev_bits;
  endfunction

  function automatic int unsigned row_idx_bits(input int unsigned mem_words,
                                               input int unsigned dev_words);
    return $clog2(mem_words / dev_words);
  endfunction

endpackage

// File: rtl/chip_row_split.sv
module chip_row_split #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFS_W  = 2,
  parameter int unsigned DEV_AW = 2,
  parameter int unsigned ROW_W  = 2,
  parameter int unsigned TAG_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DEV_AW-1:0] dev_addr,
  output logic [ROW_W-1:0]  row_idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int unsigned ROW_LSB = OFS_W + DEV_AW;
  localparam int unsigned TAG_LSB = ROW_LSB + ROW_W;

  // The byte offset field addr[OFS_W-1:0] is deliberately left unused.
  assign dev_addr = addr[ROW_LSB-1:OFS_W];
  assign row_idx  = addr[TAG_LSB-1:ROW_LSB];
  assign tag      = addr[ADDR_W-1:TAG_LSB];

  logic unused_ofs;
  assign unused_ofs = ^addr[OFS_W-1:0];
endmodule

// File: rtl/chip_row_match.sv
module chip_row_match #(
  parameter int unsigned TAG_W = 2
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] base,
  input  logic [TAG_W-1:0] ignore,
  input  logic             relaxed,
  output logic             match
);
  logic [TAG_W-1:0] bit_ok;

  for (genvar i = 0; i < TAG_W; i++) begin : g_bit
    assign bit_ok[i] = (tag[i] == base[i]) | (relaxed & ignore[i]);
  end

  assign match = &bit_ok;

  always_comb begin
    // exact mode never accepts a tag that differs from the base
    p_exact_only_r3: assert (relaxed || !match || (tag == base));
    // with every tag bit ignored, the window covers the whole tag space
    p_all_alias_r4: assert (!(relaxed && (&ignore)) || match);
    // an exact tag always matches, in either mode
    p_self_match_r4: assert ((tag != base) || match);
  end
endmodule

// File: rtl/chip_row_select.sv
module chip_row_select #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 2,
  parameter int unsigned ROW_W = 2
) (
  input  logic [ROW_W-1:0]     row_idx,
  input  logic                 enable,
  output logic [ROWS-1:0]      row_sel,
  output logic [ROWS*COLS-1:0] dev_sel
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = enable & (row_idx == ROW_W'(r));
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign dev_sel[r*COLS + c] = row_sel[r];
    end
  end

  always_comb begin
    p_one_row_r2: assert ($onehot0(row_sel));
    p_row_width_r8: assert ($countones(dev_sel) == $countones(row_sel) * COLS);
    p_enable_needed_r6: assert (enable || (dev_sel == '0));
  end
endmodule

// File: rtl/chip_row_decoder.sv
module chip_row_decoder
  import chip_row_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MEM_WORDS = 16,
  parameter int unsigned MEM_BITS  = 32,
  parameter int unsigned DEV_WORDS = 4,
  parameter int unsigned DEV_BITS  = 16,
  localparam int unsigned OFS_W  = byte_sel_bits(MEM_BITS),
  localparam int unsigned DEV_AW = dev_addr_bits(DEV_WORDS),
  localparam int unsigned ROWS   = row_count(MEM_WORDS, DEV_WORDS),
  localparam int unsigned COLS   = col_count(MEM_BITS, DEV_BITS),
  localparam int unsigned ROW_W  = row_idx_bits(MEM_WORDS, DEV_WORDS),
  localparam int unsigned TAG_W  = ADDR_W - OFS_W - DEV_AW - ROW_W
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 strobe,
  input  logic                 cfg_relaxed,
  input  logic [TAG_W-1:0]     cfg_base,
  input  logic [TAG_W-1:0]     cfg_ignore,
  output logic [DEV_AW-1:0]    dev_addr,
  output logic [ROWS-1:0]      row_sel,
  output logic [ROWS*COLS-1:0] dev_sel,
  output logic                 hit
);
  logic [ROW_W-1:0] row_idx;
  logic [TAG_W-1:0] tag;
  logic             tag_match;

  chip_row_split #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEV_AW(DEV_AW),
    .ROW_W(ROW_W), .TAG_W(TAG_W)
  ) u_split (
    .addr(addr), .dev_addr(dev_addr), .row_idx(row_idx), .tag(tag)
  );

  chip_row_match #(.TAG_W(TAG_W)) u_match (
    .tag(tag), .base(cfg_base), .ignore(cfg_ignore),
    .relaxed(cfg_relaxed), .match(tag_match)
  );

  assign hit = strobe & tag_match;

  chip_row_select #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_sel (
    .row_idx(row_idx), .enable(hit), .row_sel(row_sel), .dev_sel(dev_sel)
  );

  always_comb begin
    p_idle_quiet_r6: assert (strobe || (!hit && row_sel == '0));
    p_hit_is_select_r7: assert (hit == (row_sel != '0));
    p_miss_quiet_r7: assert (tag_match || (dev_sel == '0));
  end
endmodule

// File: tb/tb_chip_row_decoder.sv
module tb_chip_row_decoder;
  logic       clk = 1'b0;
  logic [7:0] addr;
  logic       strobe;
  logic       cfg_relaxed;
  logic [1:0] cfg_base;
  logic [1:0] cfg_ignore;
  logic [1:0] dev_addr;
  logic [3:0] row_sel;
  logic [7:0] dev_sel;
  logic       hit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  chip_row_decoder dut (
    .addr(addr), .strobe(strobe), .cfg_relaxed(cfg_relaxed),
    .cfg_base(cfg_base), .cfg_ignore(cfg_ignore),
    .dev_addr(dev_addr), .row_sel(row_sel), .dev_sel(dev_sel), .hit(hit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d relaxed=%0d base=%0d ign=%0d act=%0d exp=%0d",
               req, addr, cfg_relaxed, cfg_base, cfg_ignore, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int word_ofs, row, tag, exp_hit, exp_rows, exp_devs;
    logic [3:0] ref_rows;
    logic [7:0] ref_devs;
    logic [1:0] ref_daddr;
    logic       ref_hit;
    addr = 0; strobe = 0; cfg_relaxed = 0; cfg_base = 0; cfg_ignore = 0;
    ref_rows = 0; ref_devs = 0; ref_daddr = 0; ref_hit = 0;
    @(negedge clk); #1;
    // idle state: no strobe, nothing selected
    check("R6 idle hit", hit, 0);
    check("R6 idle rows", row_sel, 0);
    check("R6 idle devs", dev_sel, 0);

    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 4; b++)
        for (int ig = 0; ig < 4; ig++)
          for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++) begin
              @(negedge clk);
              addr = 8'(a); strobe = s[0]; cfg_relaxed = m[0];
              cfg_base = 2'(b); cfg_ignore = 2'(ig);
              #2;
              word_ofs = (a / 4) % 4;
              row      = (a / 16) % 4;
              tag      = a / 64;
              exp_hit  = 1;
              for (int k = 0; k < 2; k++) begin
                bit care;
                care = (m == 0) || (((ig >> k) & 1) == 0);
                if (care && (((tag >> k) & 1) != ((b >> k) & 1))) exp_hit = 0;
              end
              if (s == 0) exp_hit = 0;
              exp_rows = exp_hit ? (1 << row) : 0;
              exp_devs = exp_hit ? (3 << (2 * row)) : 0;

              check("R1 dev_addr", dev_addr, word_ofs);
              if (m == 0) check(ig != 0 ? "R5 exact hit ignore-mask" : "R3 exact hit", hit, exp_hit);
              else        check("R4 relaxed hit", hit, exp_hit);
              if (s == 0)        check("R6 rows quiet", row_sel, 0);
              else if (!exp_hit) check("R7 rows on miss", row_sel, 0);
              else               check("R2 row one-hot", row_sel, exp_rows);
              check("R8 device selects", dev_sel, exp_devs);
              check("R7 hit vs rows", hit, (row_sel != 0) ? 1 : 0);

              if (a % 4 == 0) begin
                ref_rows = row_sel; ref_devs = dev_sel;
                ref_daddr = dev_addr; ref_hit = hit;
              end else begin
                check("R9 offset rows", row_sel, ref_rows);
                check("R9 offset devs", dev_sel, ref_devs);
                check("R9 offset addr", dev_addr, ref_daddr);
                check("R9 offset hit", hit, ref_hit);
              end
            end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule